// File: doc/BRIEF.md
# Set-Associative Cache Hit/Miss Tracker

This block models the tag side of a read-only instruction cache. It holds no data. Each cycle it may take one read address. It splits the address into offset, set index and tag, and compares the tag with every way of the indexed set. It reports one registered outcome, hit or miss, in the next cycle. On a miss it writes the new tag into a victim way of that set. Two 32-bit counters record all accepted requests and all misses. Software divides the miss count by the request count to get the miss rate for a given capacity and associativity.

Capacity in bytes, way count, line size in bytes and address width are parameters. The line count is capacity divided by line size, and the set count is the line count divided by the way count. Every value must be a power of two, the way count may not exceed the line count, and at least one tag bit must remain. Elaboration stops on any other combination. The defaults are a 4-byte line and a 32-bit address. Replacement is strict round-robin within each set. A synchronous clear empties the cache and zeroes the counters so that a fresh run can start.

Top module: `icache_tag_tracker`

## Requirements
- R1: The low log2(LINE_BYTES) address bits are the byte offset and do not affect the lookup. Two addresses that differ only in those bits refer to the same line.
- R2: The next log2(SETS) bits select the set, and the remaining high bits form the tag. A request hits only when a valid way in the selected set holds an equal tag. An equal tag in a different set does not count as a hit.
- R3: A miss installs the tag, so a repeat of the same address in the very next cycle hits.
- R4: While the selected set has invalid ways, a miss fills the lowest-numbered invalid way. After WAYS distinct tags, all of them hit.
- R5: Once a set is full, each miss evicts the way named by that set's round-robin pointer. The order is 0, 1, ..., WAYS-1, then 0 again. The pointer steps on every miss in the set, and hits never move it.
- R6: Each set has its own round-robin pointer. Misses in one set do not change the victim order of another set.
- R7: An accepted request produces exactly one of hit or miss, high for one cycle, in the cycle after it is presented. In every other cycle both are low.
- R8: req_count increases by one for each accepted request, and miss_count increases by one for each miss. Both are 32 bits wide.
- R9: When clr is high at a clock edge, every line becomes invalid, every pointer returns to way 0 and both counters return to zero. A request presented in that same cycle is dropped: it gives no outcome, no count and no allocation.
- R10: While rst is high, the block holds the same empty state as after a clear, and hit and miss stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear: empties the cache and zeroes the counters |
| req_valid | input | 1 | A read request is present this cycle |
| req_addr | input | ADDR_W | Byte address of the read |
| hit | output | 1 | One-cycle pulse: the previous request hit |
| miss | output | 1 | One-cycle pulse: the previous request missed |
| req_count | output | 32 | Number of accepted requests since the last reset or clear |
| miss_count | output | 32 | Number of misses since the last reset or clear |

## Verification
The bench targets the following corner cases:

- **Round-robin victim order.** A design that chose the wrong victim, or that let a hit move the pointer, would evict a line the order says must survive. A later access to that line would then miss where a hit is expected.
- **Independence of the sets.** A single shared pointer would show up when a miss in a second set evicts the wrong way.
- **Offset-only address changes.** A wrong index or tag split would turn an address that differs only in its offset into a false miss. It would also let an equal tag in another set produce a false hit.
- **Clear with a request in the same cycle.** A design that failed to drop the request would show a pulse or a count of one after the clear.

Long sequential, same-set thrash and pseudo-random sweeps over a 4-set, 4-way configuration compare every outcome and both counters with an arithmetic model.

// File: rtl/ictt_pkg.sv
package ictt_pkg;

    localparam int CNT_W = 32;

    typedef logic [CNT_W-1:0] cnt_t;

    // Registered outcome of one lookup.
    typedef enum logic [1:0] {
        OUTCOME_IDLE = 2'b00,
        OUTCOME_HIT  = 2'b01,
        OUTCOME_MISS = 2'b10
    } outcome_e;

    // Lookup summary passed from the tag store to the control logic.
    typedef struct packed {
        logic any_hit;
        logic set_full;
    } lookup_t;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // Number of bits needed to index v items; zero when v is one.
    function automatic int bits_for(input int v);
        return (v <= 1) ? 0 : $clog2(v);
    endfunction

endpackage

// File: rtl/ictt_addr_split.sv
module ictt_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 4,
    parameter int IDX_RW = 4,
    parameter int TAG_W  = 26
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_RW-1:0] idx,
    output logic [TAG_W-1:0]  tag
);

    // The offset bits addr[OFF_W-1:0] are not used by the lookup.
    assign tag = addr[ADDR_W-1 -: TAG_W];

    generate
        if (IDX_W == 0) begin : g_single_set
            assign idx = '0;
        end else begin : g_multi_set
            assign idx = addr[OFF_W +: IDX_W];
        end
    endgenerate

endmodule

// File: rtl/ictt_tag_store.sv
module ictt_tag_store
    import ictt_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 26,
    parameter int IDX_RW = 4,
    parameter int WAY_RW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [IDX_RW-1:0] idx,
    input  logic [TAG_W-1:0]  tag,
    input  logic              wr_en,
    input  logic [WAY_RW-1:0] wr_way,
    output logic [WAYS-1:0]   way_valid,
    output logic [WAYS-1:0]   way_hit,
    output lookup_t           summary
);

    logic [WAYS-1:0]  vld_q  [SETS];
    logic [TAG_W-1:0] tags_q [SETS][WAYS];

    // Valid bits are reset and cleared.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
        end else if (wr_en) begin
            vld_q[idx][wr_way] <= 1'b1;
        end
    end

    // Tags need no reset: a tag only matters while its valid bit is set.
    always_ff @(posedge clk) begin
        if (wr_en && !rst && !clr) begin
            tags_q[idx][wr_way] <= tag;
        end
    end

    assign way_valid = vld_q[idx];

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign way_hit[w] = vld_q[idx][w] && (tags_q[idx][w] == tag);
        end
    endgenerate

    always_comb begin
        summary.any_hit  = |way_hit;
        summary.set_full = &way_valid;
    end

endmodule

// File: rtl/ictt_victim_sel.sv
module ictt_victim_sel #(
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int IDX_RW = 4,
    parameter int WAY_RW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [IDX_RW-1:0] idx,
    input  logic [WAYS-1:0]   way_valid,
    input  logic              advance,
    output logic [WAY_RW-1:0] victim
);

    localparam logic [WAY_RW-1:0] LAST_WAY = WAY_RW'(WAYS - 1);

    logic [WAY_RW-1:0] rr_q [SETS];
    logic [WAY_RW-1:0] free_way;
    logic              free_found;

    // Pick the lowest-numbered invalid way.
    always_comb begin
        free_way   = '0;
        free_found = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                free_way   = WAY_RW'(w);
                free_found = 1'b1;
            end
        end
    end

    assign victim = free_found ? free_way : rr_q[idx];

    // One pointer per set; it steps only on a miss in that set.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= '0;
            end
        end else if (advance) begin
            rr_q[idx] <= (rr_q[idx] == LAST_WAY) ? '0 : rr_q[idx] + 1'b1;
        end
    end

endmodule

// File: rtl/ictt_counters.sv
module ictt_counters
    import ictt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bump_req,
    input  logic bump_miss,
    output cnt_t req_cnt,
    output cnt_t miss_cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            req_cnt  <= '0;
            miss_cnt <= '0;
        end else begin
            if (bump_req) begin
                req_cnt <= req_cnt + 1'b1;
            end
            if (bump_miss) begin
                miss_cnt <= miss_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/icache_tag_tracker.sv
module icache_tag_tracker
    import ictt_pkg::*;
#(
    parameter int CAP_BYTES  = 256,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 4,
    parameter int ADDR_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              hit,
    output logic              miss,
    output logic [31:0]       req_count,
    output logic [31:0]       miss_count
);

    localparam int LINES  = CAP_BYTES / LINE_BYTES;
    localparam int SETS   = (LINES / WAYS > 0) ? LINES / WAYS : 1;
    localparam int OFF_W  = bits_for(LINE_BYTES);
    localparam int IDX_W  = bits_for(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int IDX_RW = (IDX_W > 0) ? IDX_W : 1;
    localparam int WAY_RW = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam bit CFG_OK = is_pow2(CAP_BYTES) && is_pow2(WAYS) &&
                            is_pow2(LINE_BYTES) && (CAP_BYTES >= LINE_BYTES) &&
                            (WAYS <= LINES) && (TAG_W >= 1);

    generate
        if (!CFG_OK) begin : g_cfg_bad
            $error("icache_tag_tracker: illegal capacity, way, line or address width");
        end
    endgenerate

    logic [IDX_RW-1:0] idx;
    logic [TAG_W-1:0]  tag;
    logic [WAYS-1:0]   way_valid;
    logic [WAYS-1:0]   way_hit;
    logic [WAY_RW-1:0] victim;
    lookup_t           look;
    logic              accept;
    logic              alloc;
    outcome_e          outcome_q;
    cnt_t              req_cnt;
    cnt_t              miss_cnt;

    ictt_addr_split #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .IDX_RW (IDX_RW),
        .TAG_W  (TAG_W)
    ) u_split (
        .addr (req_addr),
        .idx  (idx),
        .tag  (tag)
    );

    ictt_tag_store #(
        .SETS   (SETS),
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .IDX_RW (IDX_RW),
        .WAY_RW (WAY_RW)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .idx       (idx),
        .tag       (tag),
        .wr_en     (alloc),
        .wr_way    (victim),
        .way_valid (way_valid),
        .way_hit   (way_hit),
        .summary   (look)
    );

    ictt_victim_sel #(
        .SETS   (SETS),
        .WAYS   (WAYS),
        .IDX_RW (IDX_RW),
        .WAY_RW (WAY_RW)
    ) u_victim (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .idx       (idx),
        .way_valid (way_valid),
        .advance   (alloc),
        .victim    (victim)
    );

    ictt_counters u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .bump_req  (accept),
        .bump_miss (alloc),
        .req_cnt   (req_cnt),
        .miss_cnt  (miss_cnt)
    );

    // A clear in the same cycle drops the request.
    assign accept = req_valid && !clr;
    assign alloc  = accept && !look.any_hit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            outcome_q <= OUTCOME_IDLE;
        end else if (accept) begin
            outcome_q <= look.any_hit ? OUTCOME_HIT : OUTCOME_MISS;
        end else begin
            outcome_q <= OUTCOME_IDLE;
        end
    end

    assign hit        = (outcome_q == OUTCOME_HIT);
    assign miss       = (outcome_q == OUTCOME_MISS);
    assign req_count  = req_cnt;
    assign miss_count = miss_cnt;

endmodule

// File: rtl/ictt_checker.sv
module ictt_checker #(
    parameter int WAYS = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            clr,
    input logic            req_valid,
    input logic            hit,
    input logic            miss,
    input logic [31:0]     req_count,
    input logic [31:0]     miss_count,
    input logic [WAYS-1:0] way_hit
);

    // R2: a tag is held at most once in a set
    a_r2_unique_tag: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_hit));

    // R7: one outcome per accepted request
    a_r7_one_outcome: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !clr) |=> (hit ^ miss));

    // R7: no outcome without a request
    a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !clr) |=> (!hit && !miss));

    // R8: request counter steps with each accepted request
    a_r8_req_step: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !clr) |=> (req_count == $past(req_count) + 32'd1));

    // R8: miss counter steps with each miss pulse
    a_r8_miss_step: assert property (@(posedge clk) disable iff (rst)
        miss |-> (miss_count == $past(miss_count) + 32'd1));

    // R8: misses never exceed requests
    a_r8_order: assert property (@(posedge clk) disable iff (rst)
        miss_count <= req_count);

    // R9: clear empties counters and outputs
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (req_count == 32'd0 && miss_count == 32'd0 && !hit && !miss));

    // R10: reset state
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (req_count == 32'd0 && miss_count == 32'd0 && !hit && !miss));

endmodule

bind icache_tag_tracker ictt_checker #(.WAYS(WAYS)) u_ictt_chk (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .req_valid  (req_valid),
    .hit        (hit),
    .miss       (miss),
    .req_count  (req_count),
    .miss_count (miss_count),
    .way_hit    (way_hit)
);

// File: tb/tb_icache_tag_tracker.sv
`timescale 1ns/1ps
module tb_icache_tag_tracker;

    // Small configuration: 16 lines, 4 ways, 4 sets, 12-bit address.
    // Address bits: [1:0] offset, [3:2] set, [11:4] tag.
    localparam int CAP = 64;
    localparam int NW  = 4;
    localparam int LB  = 4;
    localparam int AW  = 12;
    localparam int NS  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          hit;
    logic          miss;
    logic [31:0]   req_count;
    logic [31:0]   miss_count;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    int  exp_req  = 0;
    int  exp_miss = 0;

    // Model state
    bit  mv [NS][NW];
    int  mt [NS][NW];
    int  mrr [NS];

    always #2.5 clk = ~clk;

    icache_tag_tracker #(
        .CAP_BYTES  (CAP),
        .WAYS       (NW),
        .LINE_BYTES (LB),
        .ADDR_W     (AW)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .hit        (hit),
        .miss       (miss),
        .req_count  (req_count),
        .miss_count (miss_count)
    );

    function automatic int mk(input int tg, input int st, input int off);
        return (tg << 4) | (st << 2) | off;
    endfunction

    function automatic void model_clear();
        for (int s = 0; s < NS; s++) begin
            mrr[s] = 0;
            for (int w = 0; w < NW; w++) begin
                mv[s][w] = 1'b0;
                mt[s][w] = 0;
            end
        end
        exp_req  = 0;
        exp_miss = 0;
    endfunction

    // Returns 1 on hit; allocates on miss.
    function automatic bit model_access(input int a);
        int st;
        int tg;
        int vw;
        bit found;
        st = (a >> 2) & 3;
        tg = (a >> 4) & 255;
        for (int w = 0; w < NW; w++) begin
            if (mv[st][w] && mt[st][w] == tg) return 1'b1;
        end
        found = 1'b0;
        vw    = mrr[st];
        for (int w = NW - 1; w >= 0; w--) begin
            if (!mv[st][w]) begin
                vw    = w;
                found = 1'b1;
            end
        end
        mv[st][vw] = 1'b1;
        mt[st][vw] = tg;
        mrr[st]    = (mrr[st] + 1) % NW;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic check_counts(input string rq);
        chk(req_count == 32'(exp_req), rq, "req_count", req_count, exp_req);
        chk(miss_count == 32'(exp_miss), rq, "miss_count", miss_count, exp_miss);
    endtask

    // exp: 1 hit, 0 miss, -1 take the model's answer
    task automatic access(input int a, input int exp, input string rq);
        bit mh;
        bit eh;
        mh = model_access(a);
        eh = (exp < 0) ? mh : bit'(exp);
        req_valid = 1'b1;
        req_addr  = AW'(a);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        exp_req++;
        if (!eh) exp_miss++;
        chk(hit == eh && miss == !eh, rq, "hit flag", hit, eh);
        check_counts("R8");
    endtask

    task automatic idle_cycle();
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(!hit && !miss, "R7", "idle pulse", {hit, miss}, 0);
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        chk(!hit && !miss, "R10", "outputs in reset", {hit, miss}, 0);
        chk(req_count == 0 && miss_count == 0, "R10", "counts in reset", req_count, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: offset bits do not matter
        access(mk(5, 1, 0), 0, "R1");
        access(mk(5, 1, 3), 1, "R1");
        access(mk(5, 1, 2), 1, "R1");

        // R3: back-to-back repeat hits
        access(mk(9, 2, 0), 0, "R3");
        access(mk(9, 2, 0), 1, "R3");

        // R2: equal tag in another set is a miss; other tag same set misses
        access(mk(9, 3, 0), 0, "R2");
        access(mk(10, 2, 0), 0, "R2");
        access(mk(9, 2, 1), 1, "R2");

        idle_cycle();

        // R4: fill set 0 with four tags, then all hit
        for (int t = 1; t <= 4; t++) access(mk(t, 0, 0), 0, "R4");
        for (int t = 1; t <= 4; t++) access(mk(t, 0, 0), 1, "R4");

        // R5: round-robin victims 0,1,2; hits do not move the pointer
        access(mk(5, 0, 0), 0, "R5");   // evicts tag 1 (way 0)
        access(mk(2, 0, 0), 1, "R5");
        access(mk(3, 0, 0), 1, "R5");
        access(mk(4, 0, 0), 1, "R5");
        access(mk(1, 0, 0), 0, "R5");   // evicts tag 2 (way 1)
        access(mk(3, 0, 0), 1, "R5");
        access(mk(5, 0, 0), 1, "R5");
        access(mk(2, 0, 0), 0, "R5");   // evicts tag 3 (way 2)
        access(mk(4, 0, 0), 1, "R5");
        access(mk(3, 0, 0), 0, "R5");   // evicts tag 4 (way 3)
        access(mk(4, 0, 0), 0, "R5");   // wraps to way 0, evicts tag 5
        access(mk(5, 0, 0), 0, "R5");

        // R6: set 1 keeps its own pointer (way 0 holds tag 5)
        access(mk(20, 1, 0), 0, "R6");
        access(mk(21, 1, 0), 0, "R6");
        access(mk(22, 1, 0), 0, "R6");
        access(mk(23, 1, 0), 0, "R6");  // set 1 pointer at 0: evicts tag 5
        access(mk(5, 1, 0), 0, "R6");
        access(mk(21, 1, 0), 1, "R6");
        access(mk(22, 1, 0), 1, "R6");
        access(mk(23, 1, 0), 1, "R6");

        idle_cycle();
        idle_cycle();

        // R9: clear with a simultaneous request
        clr = 1'b1;
        req_valid = 1'b1;
        req_addr  = AW'(mk(9, 2, 0));
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
        req_valid = 1'b0;
        model_clear();
        chk(!hit && !miss, "R9", "pulse on clear", {hit, miss}, 0);
        chk(req_count == 0 && miss_count == 0, "R9", "counts after clear", req_count, 0);
        access(mk(9, 2, 0), 0, "R9");
        access(mk(21, 1, 0), 0, "R9");

        // Sweep: every line address in order, twice
        for (int pass = 0; pass < 2; pass++)
            for (int a = 0; a < (1 << AW); a += LB) access(a, -1, "R2");

        // Sweep: five tags cycling through one set
        for (int r = 0; r < 20; r++)
            for (int t = 0; t < 5; t++) access(mk(100 + t, 3, r & 3), -1, "R5");

        // Sweep: pseudo-random addresses over a narrow tag range
        begin
            logic [15:0] lf;
            lf = 16'hACE1;
            for (int i = 0; i < 3000; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                access({lf[7:4] & 4'h7, lf[3:0], 4'h0} >> 4 << 4 | int'(lf[11:8]) , -1, "R4");
            end
        end

        // R10: reset mid-run
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        chk(!hit && !miss, "R10", "outputs after reset", {hit, miss}, 0);
        chk(req_count == 0 && miss_count == 0, "R10", "counts after reset", req_count, 0);
        access(mk(5, 1, 0), 0, "R10");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule